// File: doc/BRIEF.md
# Reset Sequence Selection Controller

This controller decides which reset sequence a chip runs and steps through the three phases of that sequence. It has three kinds of trigger. Destructive requests come from the supply monitors. The bidirectional external reset pin is active low. Internal functional sources form the third kind. The sequence chosen depends on which trigger fired, on each trigger's long/short setting, and on a stored self-test enable bit.

While a sequence runs, the controller holds the internal reset and may pull the pin low. It gives a one-cycle strobe that starts the built-in self-test in the self-test variants. At the end of the last phase it releases its own pull-down. It then waits until the synchronized pin is high before it lets the chip run. An external driver holding the pin low therefore extends the sequence.

Phase lengths are parameters for each class of sequence. The analog detectors and the self-test engine are outside this block.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Any bit of `dest_req` seen while idle starts sequence code 1 (destructive with self-test) when `bist_en`=1, or code 2 (destructive without self-test) when `bist_en`=0. The level of the pin does not matter.
- R2: A synchronized falling edge of `pin_in` seen while idle starts a sequence, chosen as follows:
  - `pin_long_cfg`=1 and `bist_en`=1 gives code 3 (external long with self-test).
  - `pin_long_cfg`=1 and `bist_en`=0 gives code 4 (functional long).
  - `pin_long_cfg`=0 gives code 5 (functional short).
- R3: The pin can start a sequence only after it has been seen high since reset. A pin held low from reset starts nothing.
- R4: `func_req[i]` starts code 4 when `func_long_cfg[i]`=1 and code 5 otherwise. When several requests arrive together:
  - the lowest index wins among the functional sources;
  - a destructive request beats any functional request in the same cycle.
- R5: A sequence lasts P1+P2+P3 cycles of its class (destructive, long for codes 3 and 4, short for code 5), followed by a hold step. `busy` clears one cycle after the synchronized pin is seen high in the hold step. `int_rst` falls one cycle before `busy`.
- R6: If the pin is held low past the end of phase 3, `busy` and `int_rst` stay high until the pin is released.
- R7: `pin_pd_en` is high during phases 1 to 3 in three cases: destructive sequences, pin-triggered sequences, and functional sequences whose `func_pin_drv` bit is 1. It is never high for a functional sequence whose drive bit is 0.
- R8: `bist_run` pulses for exactly one cycle, on the first cycle of phase 2, and only for codes 1 and 3.
- R9: A destructive request during a non-destructive sequence restarts the controller in phase 1 of a destructive sequence. All other requests that arrive while busy are ignored, including destructive ones during a destructive sequence.
- R10: `seq_kind` is 0 when idle. It holds the running code for the whole sequence and changes only on an R9 restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| dest_req | input | N_DEST | Destructive reset requests |
| pin_in | input | 1 | Level of the external reset pin (low = asserted) |
| pin_long_cfg | input | 1 | Pin trigger uses long reset (1) or short reset (0) |
| bist_en | input | 1 | Stored self-test enable |
| func_req | input | N_FUNC | Functional reset requests |
| func_long_cfg | input | N_FUNC | Per-source long (1) / short (0) selection |
| func_pin_drv | input | N_FUNC | Per-source enable to pull the pin low |
| int_rst | output | 1 | Internal reset to the chip |
| bist_run | output | 1 | One-cycle self-test start strobe |
| pin_pd_en | output | 1 | Enable for the pin pull-down driver |
| busy | output | 1 | Sequence in progress |
| seq_kind | output | 3 | Code of the running sequence (0 when idle) |

## Verification
The bound checker watches, on every cycle, the rules that hold whatever the stimulus:
- the idle code is zero;
- the self-test strobe lasts one cycle and occurs only in the self-test codes;
- the pull-down appears only under internal reset;
- `int_rst` falls ahead of `busy`;
- a destructive code stays fixed once it is running.

Other behaviour can only be shown by the bench's scenarios and scoreboard. This covers the choice of code for each trigger and configuration, and the exact sequence length including the hold step. It also covers the arming of the pin after reset, the effect of the drive enable, request priority, the destructive restart, and the extension by a held pin.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        SK_NONE          = 3'd0,
        SK_DEST_BIST     = 3'd1,
        SK_DEST_PLAIN    = 3'd2,
        SK_EXT_LONG_BIST = 3'd3,
        SK_FUNC_LONG     = 3'd4,
        SK_FUNC_SHORT    = 3'd5
    } seq_kind_e;

    typedef enum logic [2:0] {
        PH_RUN   = 3'd0,
        PH_ONE   = 3'd1,
        PH_TWO   = 3'd2,
        PH_THREE = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    function automatic logic is_dest(seq_kind_e k);
        return (k == SK_DEST_BIST) || (k == SK_DEST_PLAIN);
    endfunction

    function automatic logic is_bist(seq_kind_e k);
        return (k == SK_DEST_BIST) || (k == SK_EXT_LONG_BIST);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsc_pin_sync.sv
module rsc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_s,
    output logic pin_fall
);
    // STAGES synchronizer flops plus one flop holding the previous synchronized level
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pin_s    = sh_q[STAGES-1];
    assign pin_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/rsc_select.sv
module rsc_select
    import rsc_pkg::*;
#(
    parameter int N_FUNC = 4
) (
    input  logic              dest_any,
    input  logic              pin_fall,
    input  logic              pin_long_cfg,
    input  logic              bist_en,
    input  logic [N_FUNC-1:0] func_req,
    input  logic [N_FUNC-1:0] func_long_cfg,
    input  logic [N_FUNC-1:0] func_pin_drv,
    output logic              sel_valid,
    output seq_kind_e         sel_kind,
    output logic              sel_drive
);
    logic      f_hit;
    seq_kind_e f_kind;
    logic      f_drive;

    // Scan from the top index down so the lowest requesting index is the last to write
    always_comb begin
        f_hit   = 1'b0;
        f_kind  = SK_NONE;
        f_drive = 1'b0;
        for (int i = N_FUNC - 1; i >= 0; i--) begin
            if (func_req[i]) begin
                f_hit   = 1'b1;
                f_kind  = func_long_cfg[i] ? SK_FUNC_LONG : SK_FUNC_SHORT;
                f_drive = func_pin_drv[i];
            end
        end
    end

    always_comb begin
        sel_valid = 1'b1;
        sel_drive = 1'b1;
        if (dest_any) begin
            sel_kind = bist_en ? SK_DEST_BIST : SK_DEST_PLAIN;
        end else if (pin_fall) begin
            if (!pin_long_cfg)  sel_kind = SK_FUNC_SHORT;
            else if (bist_en)   sel_kind = SK_EXT_LONG_BIST;
            else                sel_kind = SK_FUNC_LONG;
        end else if (f_hit) begin
            sel_kind  = f_kind;
            sel_drive = f_drive;
        end else begin
            sel_valid = 1'b0;
            sel_kind  = SK_NONE;
            sel_drive = 1'b0;
        end
    end
endmodule

// File: rtl/rsc_dur.sv
module rsc_dur
    import rsc_pkg::*;
#(
    parameter int DEST_P1  = 4,
    parameter int DEST_P2  = 5,
    parameter int DEST_P3  = 6,
    parameter int LONG_P1  = 3,
    parameter int LONG_P2  = 4,
    parameter int LONG_P3  = 5,
    parameter int SHORT_P1 = 2,
    parameter int SHORT_P2 = 2,
    parameter int SHORT_P3 = 2,
    parameter int CW       = 4
) (
    input  seq_kind_e       kind,
    output logic [CW-1:0]   len1,
    output logic [CW-1:0]   len2,
    output logic [CW-1:0]   len3
);
    always_comb begin
        case (kind)
            SK_DEST_BIST, SK_DEST_PLAIN: begin
                len1 = CW'(DEST_P1); len2 = CW'(DEST_P2); len3 = CW'(DEST_P3);
            end
            SK_EXT_LONG_BIST, SK_FUNC_LONG: begin
                len1 = CW'(LONG_P1); len2 = CW'(LONG_P2); len3 = CW'(LONG_P3);
            end
            SK_FUNC_SHORT: begin
                len1 = CW'(SHORT_P1); len2 = CW'(SHORT_P2); len3 = CW'(SHORT_P3);
            end
            default: begin
                len1 = CW'(1); len2 = CW'(1); len3 = CW'(1);
            end
        endcase
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int N_DEST   = 2,
    parameter int N_FUNC   = 4,
    parameter int SYNC_FF  = 2,
    parameter int DEST_P1  = 4,
    parameter int DEST_P2  = 5,
    parameter int DEST_P3  = 6,
    parameter int LONG_P1  = 3,
    parameter int LONG_P2  = 4,
    parameter int LONG_P3  = 5,
    parameter int SHORT_P1 = 2,
    parameter int SHORT_P2 = 2,
    parameter int SHORT_P3 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEST-1:0] dest_req,
    input  logic              pin_in,
    input  logic              pin_long_cfg,
    input  logic              bist_en,
    input  logic [N_FUNC-1:0] func_req,
    input  logic [N_FUNC-1:0] func_long_cfg,
    input  logic [N_FUNC-1:0] func_pin_drv,
    output logic              int_rst,
    output logic              bist_run,
    output logic              pin_pd_en,
    output logic              busy,
    output logic [2:0]        seq_kind
);
    localparam int MAX_LEN = imax(imax(imax(DEST_P1, DEST_P2), imax(DEST_P3, LONG_P1)),
                                  imax(imax(LONG_P2, LONG_P3),
                                       imax(SHORT_P1, imax(SHORT_P2, SHORT_P3))));
    localparam int CW = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e        phase;
        seq_kind_e     kind;
        logic          drive;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic          pin_s, pin_fall;
    logic          sel_valid, sel_drive;
    seq_kind_e     sel_kind;
    logic [CW-1:0] s_len1, s_len2, s_len3;
    logic [CW-1:0] c_len1, c_len2, c_len3;
    logic          dest_restart;

    rsc_pin_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_s    (pin_s),
        .pin_fall (pin_fall)
    );

    rsc_select #(.N_FUNC(N_FUNC)) u_sel (
        .dest_any      (|dest_req),
        .pin_fall      (pin_fall),
        .pin_long_cfg  (pin_long_cfg),
        .bist_en       (bist_en),
        .func_req      (func_req),
        .func_long_cfg (func_long_cfg),
        .func_pin_drv  (func_pin_drv),
        .sel_valid     (sel_valid),
        .sel_kind      (sel_kind),
        .sel_drive     (sel_drive)
    );

    // Lengths for a sequence about to start
    rsc_dur #(
        .DEST_P1(DEST_P1), .DEST_P2(DEST_P2), .DEST_P3(DEST_P3),
        .LONG_P1(LONG_P1), .LONG_P2(LONG_P2), .LONG_P3(LONG_P3),
        .SHORT_P1(SHORT_P1), .SHORT_P2(SHORT_P2), .SHORT_P3(SHORT_P3),
        .CW(CW)
    ) u_dur_start (
        .kind (sel_kind),
        .len1 (s_len1),
        .len2 (s_len2),
        .len3 (s_len3)
    );

    // Lengths for the sequence that is running
    rsc_dur #(
        .DEST_P1(DEST_P1), .DEST_P2(DEST_P2), .DEST_P3(DEST_P3),
        .LONG_P1(LONG_P1), .LONG_P2(LONG_P2), .LONG_P3(LONG_P3),
        .SHORT_P1(SHORT_P1), .SHORT_P2(SHORT_P2), .SHORT_P3(SHORT_P3),
        .CW(CW)
    ) u_dur_cur (
        .kind (st_q.kind),
        .len1 (c_len1),
        .len2 (c_len2),
        .len3 (c_len3)
    );

    // Restart applies only when a destructive request meets a non-destructive sequence
    assign dest_restart = sel_valid && is_dest(sel_kind) && !is_dest(st_q.kind);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_RUN: begin
                if (sel_valid) begin
                    st_d.phase = PH_ONE;
                    st_d.kind  = sel_kind;
                    st_d.drive = sel_drive;
                    st_d.cnt   = s_len1 - CW'(1);
                end
            end
            PH_ONE, PH_TWO, PH_THREE: begin
                if (dest_restart) begin
                    st_d.phase = PH_ONE;
                    st_d.kind  = sel_kind;
                    st_d.drive = 1'b1;
                    st_d.cnt   = s_len1 - CW'(1);
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end else if (st_q.phase == PH_ONE) begin
                    st_d.phase = PH_TWO;
                    st_d.cnt   = c_len2 - CW'(1);
                end else if (st_q.phase == PH_TWO) begin
                    st_d.phase = PH_THREE;
                    st_d.cnt   = c_len3 - CW'(1);
                end else begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                end
            end
            PH_HOLD: begin
                if (dest_restart) begin
                    st_d.phase = PH_ONE;
                    st_d.kind  = sel_kind;
                    st_d.drive = 1'b1;
                    st_d.cnt   = s_len1 - CW'(1);
                end else if (pin_s) begin
                    st_d.phase = PH_RUN;
                    st_d.kind  = SK_NONE;
                    st_d.drive = 1'b0;
                end
            end
            default: begin
                st_d.phase = PH_RUN;
                st_d.kind  = SK_NONE;
                st_d.drive = 1'b0;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_RUN;
            st_q.kind  <= SK_NONE;
            st_q.drive <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_RUN);
    assign int_rst   = busy && !((st_q.phase == PH_HOLD) && pin_s);
    assign pin_pd_en = st_q.drive && (st_q.phase inside {PH_ONE, PH_TWO, PH_THREE});
    assign bist_run  = (st_q.phase == PH_TWO) && is_bist(st_q.kind)
                       && (st_q.cnt == c_len2 - CW'(1));
    assign seq_kind  = st_q.kind;

    // c_len1 is only needed at start, which uses s_len1; fold it in so nothing dangles
    logic len1_seen;
    assign len1_seen = |c_len1;
    logic unused_ok;
    assign unused_ok = len1_seen | |s_len2 | |s_len3;
endmodule

// File: rtl/rsc_seq_chk.sv
module rsc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       int_rst,
    input logic       bist_run,
    input logic       pin_pd_en,
    input logic       busy,
    input logic [2:0] seq_kind
);
    AST_KIND_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> seq_kind == 3'd0);  // R10

    AST_BIST_KIND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bist_run |-> busy && (seq_kind == 3'd1 || seq_kind == 3'd3));  // R8

    AST_BIST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bist_run |=> !bist_run);  // R8

    AST_PD_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pd_en |-> int_rst);  // R7

    AST_RESET_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> busy);  // R5

    AST_RESET_LEADS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(int_rst));  // R5

    AST_DEST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && ($past(seq_kind) == 3'd1 || $past(seq_kind) == 3'd2)
        |-> $stable(seq_kind));  // R9
endmodule

bind rst_seq_ctrl rsc_seq_chk i_rsc_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_rst   (int_rst),
    .bist_run  (bist_run),
    .pin_pd_en (pin_pd_en),
    .busy      (busy),
    .seq_kind  (seq_kind)
);

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;
    localparam int NF = 4;
    localparam int ND = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] dest_req = '0;
    logic          ext_low = 1'b0;
    logic          pin_long_cfg = 1'b1;
    logic          bist_en = 1'b1;
    logic [NF-1:0] func_req = '0;
    logic [NF-1:0] func_long_cfg = '0;
    logic [NF-1:0] func_pin_drv = '0;
    logic          int_rst, bist_run, pin_pd_en, busy;
    logic [2:0]    seq_kind;
    logic          pin_line;

    // Pin is pulled up; low when the external driver or the block pulls it down
    assign pin_line = ~(ext_low | pin_pd_en);

    always #10 clk = ~clk;

    rst_seq_ctrl i_rst_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .dest_req(dest_req), .pin_in(pin_line),
        .pin_long_cfg(pin_long_cfg), .bist_en(bist_en), .func_req(func_req),
        .func_long_cfg(func_long_cfg), .func_pin_drv(func_pin_drv),
        .int_rst(int_rst), .bist_run(bist_run), .pin_pd_en(pin_pd_en),
        .busy(busy), .seq_kind(seq_kind)
    );

    typedef struct {
        int    kind;
        int    len;
        int    bist;
        int    pd;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int k, int l, int b, int p, string tag);
        exp_t e;
        e.kind = k; e.len = l; e.bist = b; e.pd = p; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one segment per busy stretch or per code change while busy
    bit in_seg = 0;
    int cur_kind, m_len, m_bist, m_pd;

    task automatic close_seg();
        exp_t e;
        if (sb_q.size() == 0) begin
            chk("R10", "unexpected sequence code", cur_kind, -1);
        end else begin
            e = sb_q.pop_front();
            chk(e.tag, "sequence code", cur_kind, e.kind);
            chk(e.tag, "self-test pulses", m_bist, e.bist);
            if (e.len >= 0) chk(e.tag, "busy length", m_len, e.len);
            if (e.pd >= 0)  chk(e.tag, "pull-down seen", m_pd, e.pd);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_seg && (!busy || int'(seq_kind) != cur_kind)) begin
                close_seg();
                in_seg = 0;
            end
            if (busy && !in_seg) begin
                in_seg = 1; cur_kind = int'(seq_kind);
                m_len = 0; m_bist = 0; m_pd = 0;
            end
            if (busy) begin
                m_len++;
                m_bist += int'(bist_run);
                if (pin_pd_en) m_pd = 1;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_press();
        @(negedge clk) ext_low = 1'b1;
        repeat (4) @(negedge clk);
        ext_low = 1'b0;
    endtask

    task automatic func_pulse(logic [NF-1:0] m);
        @(negedge clk) func_req = m;
        @(negedge clk) func_req = '0;
    endtask

    task automatic dest_pulse(logic [ND-1:0] m);
        @(negedge clk) dest_req = m;
        @(negedge clk) dest_req = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Pin held low through reset: must not arm (R3)
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset busy", busy, 0);
        chk("R10", "reset int_rst", int_rst, 0);
        chk("R10", "reset pull-down", pin_pd_en, 0);
        chk("R10", "reset code", seq_kind, 0);
        chk("R10", "reset strobe", bist_run, 0);
        repeat (10) @(negedge clk);
        chk("R3", "no start from pin low since reset", busy, 0);
        ext_low = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3", "no start on release", busy, 0);

        // R2: pin trigger in each configuration
        pin_long_cfg = 1; bist_en = 1;
        push(3, 15, 1, 1, "R2"); pin_press(); wait_idle();
        bist_en = 0;
        push(4, 15, 0, 1, "R2"); pin_press(); wait_idle();
        pin_long_cfg = 0;
        push(5, 9, 0, 1, "R2"); pin_press(); wait_idle();
        pin_long_cfg = 1;

        // R1: destructive, both self-test settings
        bist_en = 1;
        push(1, 18, 1, 1, "R1"); dest_pulse(2'b01); wait_idle();
        bist_en = 0;
        push(2, 18, 0, 1, "R1"); dest_pulse(2'b10); wait_idle();

        // R4/R7: functional sources with and without drive
        func_long_cfg = 4'b0010; func_pin_drv = 4'b0010;
        push(4, 15, 0, 1, "R7"); func_pulse(4'b0010); wait_idle();
        push(5, 7, 0, 0, "R7"); func_pulse(4'b0100); wait_idle();
        // lowest index wins: [0] long no drive, [1] short
        func_long_cfg = 4'b0001; func_pin_drv = 4'b0000;
        push(4, 13, 0, 0, "R4"); func_pulse(4'b0011); wait_idle();
        // destructive beats functional in the same cycle
        bist_en = 1;
        push(1, 18, 1, 1, "R4");
        @(negedge clk) begin dest_req = 2'b01; func_req = 4'b0001; end
        @(negedge clk) begin dest_req = '0; func_req = '0; end
        wait_idle();

        // R9: other requests while busy are ignored
        func_long_cfg = 4'b1001; func_pin_drv = 4'b0000;
        push(4, 13, 0, 0, "R9");
        func_pulse(4'b1000);
        func_req = 4'b0001; ext_low = 1'b1;
        @(negedge clk) func_req = '0;
        @(negedge clk) ext_low = 1'b0;
        wait_idle();

        // R9: destructive restart of a functional sequence
        func_long_cfg = 4'b0000;
        push(5, -1, 0, 0, "R9");
        push(1, 18, 1, 1, "R9");
        func_pulse(4'b0100);
        repeat (2) @(negedge clk);
        dest_pulse(2'b01);
        wait_idle();

        // R9: destructive during destructive is ignored
        push(1, 18, 1, 1, "R9");
        dest_pulse(2'b10);
        repeat (4) @(negedge clk);
        dest_pulse(2'b01);
        wait_idle();

        // R6: pin held low extends the sequence; destructive still starts
        bist_en = 0;
        push(2, -1, 0, 1, "R6");
        @(negedge clk) begin ext_low = 1'b1; dest_req = 2'b01; end
        @(negedge clk) dest_req = '0;
        repeat (40) @(negedge clk);
        chk("R6", "busy while pin held", busy, 1);
        chk("R6", "int_rst while pin held", int_rst, 1);
        ext_low = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5", "busy two cycles after release", busy, 1);
        @(negedge clk);
        chk("R5", "busy three cycles after release", busy, 0);
        repeat (5) @(negedge clk);

        chk("R10", "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule